// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbitration

This block is a 2048-word by 8-bit synchronous memory with two independent access ports, called left and right. Each port has its own enable, write select, output enable, address, write data, read data, read-valid flag and active-low busy flag. Both ports may work anywhere in the array in the same cycle. Reads are registered. Writes take effect at the clock edge.

When both ports are enabled on the same address, an arbiter gives the location to one port and pulls the other port's busy flag low. The port whose access was already in place in the previous cycle wins. A busy port cannot write. A busy port that keeps reading the same location keeps its old read value until it is released or changes its own access.

In slave mode the busy pins become inputs, so several devices can run side by side to make a wider word. The master decides the arbitration, and each slave only obeys the busy flags it receives.

Top module: `twin_port_ram`

## Requirements
- R1: While reset is held and in the first cycle after it, both busy flags read 1 (inactive), both read-data outputs are 0 and both read-valid flags are 0.
- R2: A port with enable=1 and write select=0 reads. Its read data shows the word at its address after the next rising edge. Its read-valid flag after that edge equals enable AND read AND output enable of the previous cycle.
- R3: A port writes its data at the edge only while enable=1 and write select=1. With either of them at 0, memory is not changed.
- R4: Both ports may read the same address in the same cycle, and both receive the stored word.
- R5: When both ports are enabled on equal addresses, the port whose enable and address were already unchanged from the previous cycle wins. Only the other port's busy flag goes to 0, in the same cycle, and it stays there while the match lasts.
- R6: If both ports start a matching access in the same cycle, the left port wins and the right busy flag goes to 0.
- R7: A busy flag returns to 1 in the same cycle in which the addresses differ or either enable is 0.
- R8: A write from a port whose busy flag is 0 does not change memory.
- R9: A reading port whose busy flag is 0 keeps its read data while its enable, address and write select are unchanged from the previous cycle, even if the winner writes that word. After release it shows the new word.
- R10: In slave mode each busy output copies its busy input. A busy input at 0 blocks that port's write and holds its read, exactly as in the master.
- R11: The two ports may write different addresses in the same cycle, and both writes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enL | input | 1 | Left port enable |
| wrSelL | input | 1 | Left write select, 1 = write, 0 = read |
| oeL | input | 1 | Left output enable, gates the read-valid flag |
| addrL | input | 11 | Left word address |
| wdataL | input | 8 | Left write data |
| busyInNL | input | 1 | Left busy input, used in slave mode only, active low |
| rdataL | output | 8 | Left registered read data |
| rvalidL | output | 1 | Left read-valid flag |
| busyNL | output | 1 | Left busy flag, active low |
| enR | input | 1 | Right port enable |
| wrSelR | input | 1 | Right write select, 1 = write, 0 = read |
| oeR | input | 1 | Right output enable |
| addrR | input | 11 | Right word address |
| wdataR | input | 8 | Right write data |
| busyInNR | input | 1 | Right busy input, used in slave mode only, active low |
| rdataR | output | 8 | Right registered read data |
| rvalidR | output | 1 | Right read-valid flag |
| busyNR | output | 1 | Right busy flag, active low |

## Verification
The busy flags are combinational from the port inputs and the registered owner, so they are due in the same cycle as the stimulus. The bench samples them 1 ns after driving, before the next rising edge. Read data, read-valid and the effect of a write are due one edge later, so the bench samples them 1 ns after that edge, using expected values computed from the memory contents before the edge. A slave copy fed with the master's busy flags is compared in every cycle with the same expected values.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes from control to datapath, one set per port
  typedef struct packed {
    logic wr;    // commit write data at this edge
    logic load;  // refresh the read register at this edge
    logic vld;   // next value of the read-valid flag
  } portCtl_t;

endpackage

// File: rtl/tpr_arbiter.sv
module tpr_arbiter
  import tpr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter bit SLAVE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en       [2],
  input  logic              wrSel    [2],
  input  logic              oe       [2],
  input  logic [ADDR_W-1:0] addr     [2],
  input  logic              extBusyN [2],
  output portCtl_t          ctl      [2],
  output logic              busyN    [2]
);

  localparam int NPORT = 2;

  owner_e            ownerQ, ownerNext;
  logic              prevEn   [NPORT];
  logic              prevWr   [NPORT];
  logic [ADDR_W-1:0] prevAddr [NPORT];
  logic              stable   [NPORT];
  logic              ctrlSame [NPORT];
  logic              busyInt  [NPORT];
  logic              busyEff  [NPORT];
  logic              matchNow;

  assign matchNow = en[0] && en[1] && (addr[0] == addr[1]);

  // ownership: kept while the match lasts; a new match goes to the
  // port that was already in place, ties go to the left port
  always_comb begin
    ownerNext = OWN_NONE;
    if (matchNow) begin
      if (ownerQ != OWN_NONE)          ownerNext = ownerQ;
      else if (stable[1] && !stable[0]) ownerNext = OWN_RIGHT;
      else                              ownerNext = OWN_LEFT;
    end
  end

  assign busyInt[0] = matchNow && (ownerNext == OWN_RIGHT);
  assign busyInt[1] = matchNow && (ownerNext == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ownerQ <= OWN_NONE;
      for (int i = 0; i < NPORT; i++) begin
        prevEn[i]   <= 1'b0;
        prevWr[i]   <= 1'b0;
        prevAddr[i] <= '0;
      end
    end else begin
      ownerQ <= ownerNext;
      for (int i = 0; i < NPORT; i++) begin
        prevEn[i]   <= en[i];
        prevWr[i]   <= wrSel[i];
        prevAddr[i] <= addr[i];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign stable[p]   = en[p] && prevEn[p] && (addr[p] == prevAddr[p]);
    assign ctrlSame[p] = stable[p] && (wrSel[p] == prevWr[p]);
    assign busyEff[p]  = SLAVE_MODE ? !extBusyN[p] : busyInt[p];
    assign busyN[p]    = !busyEff[p];
    assign ctl[p].wr   = en[p] && wrSel[p] && !busyEff[p];
    assign ctl[p].load = en[p] && !wrSel[p] && !(busyEff[p] && ctrlSame[p]);
    assign ctl[p].vld  = en[p] && !wrSel[p] && oe[p];
  end

endmodule

// File: rtl/tpr_datapath.sv
module tpr_datapath
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr   [2],
  input  logic [DATA_W-1:0] wdata  [2],
  input  portCtl_t          ctl    [2],
  output logic [DATA_W-1:0] rdata  [2],
  output logic              rvalid [2]
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPORT = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  // right commits first so that the left port wins an equal-address
  // double write (only reachable in slave mode)
  always_ff @(posedge clk) begin
    if (ctl[1].wr) mem[addr[1]] <= wdata[1];
    if (ctl[0].wr) mem[addr[0]] <= wdata[0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DATA_W-1:0] rdQ;
    logic              vldQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        rdQ  <= '0;
        vldQ <= 1'b0;
      end else begin
        vldQ <= ctl[p].vld;
        if (ctl[p].load) rdQ <= mem[addr[p]];
      end
    end
    assign rdata[p]  = rdQ;
    assign rvalid[p] = vldQ;
  end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter bit SLAVE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enL,
  input  logic              wrSelL,
  input  logic              oeL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wdataL,
  input  logic              busyInNL,
  output logic [DATA_W-1:0] rdataL,
  output logic              rvalidL,
  output logic              busyNL,
  input  logic              enR,
  input  logic              wrSelR,
  input  logic              oeR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wdataR,
  input  logic              busyInNR,
  output logic [DATA_W-1:0] rdataR,
  output logic              rvalidR,
  output logic              busyNR
);

  logic              en     [2];
  logic              wrSel  [2];
  logic              oe     [2];
  logic [ADDR_W-1:0] addr   [2];
  logic [DATA_W-1:0] wdata  [2];
  logic              extB   [2];
  logic              busyN  [2];
  logic [DATA_W-1:0] rdata  [2];
  logic              rvalid [2];
  portCtl_t          ctl    [2];

  assign en[0]    = enL;     assign en[1]    = enR;
  assign wrSel[0] = wrSelL;  assign wrSel[1] = wrSelR;
  assign oe[0]    = oeL;     assign oe[1]    = oeR;
  assign addr[0]  = addrL;   assign addr[1]  = addrR;
  assign wdata[0] = wdataL;  assign wdata[1] = wdataR;
  assign extB[0]  = busyInNL; assign extB[1] = busyInNR;

  tpr_arbiter #(.ADDR_W(ADDR_W), .SLAVE_MODE(SLAVE_MODE)) u_ctl (
    .clk(clk), .rst(rst), .en(en), .wrSel(wrSel), .oe(oe), .addr(addr),
    .extBusyN(extB), .ctl(ctl), .busyN(busyN)
  );

  tpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .ctl(ctl),
    .rdata(rdata), .rvalid(rvalid)
  );

  assign rdataL  = rdata[0];  assign rdataR  = rdata[1];
  assign rvalidL = rvalid[0]; assign rvalidR = rvalid[1];
  assign busyNL  = busyN[0];  assign busyNR  = busyN[1];

endmodule

// File: rtl/twin_port_ram_checker.sv
module twin_port_ram_checker #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter bit SLAVE_MODE = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              enL,
  input logic              wrSelL,
  input logic              oeL,
  input logic [ADDR_W-1:0] addrL,
  input logic              busyInNL,
  input logic [DATA_W-1:0] rdataL,
  input logic              rvalidL,
  input logic              busyNL,
  input logic              enR,
  input logic              wrSelR,
  input logic [ADDR_W-1:0] addrR,
  input logic [DATA_W-1:0] rdataR,
  input logic              busyNR
);

  logic              pEnL, pEnR, pWrL, pWrR, pMatch;
  logic [ADDR_W-1:0] pAddrL, pAddrR;
  logic              matchNow, newL, newR;

  always_ff @(posedge clk) begin
    if (rst) begin
      pEnL <= 1'b0; pEnR <= 1'b0; pWrL <= 1'b0; pWrR <= 1'b0; pMatch <= 1'b0;
      pAddrL <= '0; pAddrR <= '0;
    end else begin
      pEnL <= enL; pEnR <= enR; pWrL <= wrSelL; pWrR <= wrSelR;
      pAddrL <= addrL; pAddrR <= addrR; pMatch <= matchNow;
    end
  end

  assign matchNow = enL && enR && (addrL == addrR);
  assign newL     = !(pEnL && addrL == pAddrL);
  assign newR     = !(pEnR && addrR == pAddrR);

  assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !SLAVE_MODE |-> (busyNL || busyNR));

  assert_busy_needs_match_R7: assert property (@(posedge clk) disable iff (rst)
    (!SLAVE_MODE && (!busyNL || !busyNR)) |-> matchNow);

  assert_tie_left_R6: assert property (@(posedge clk) disable iff (rst)
    (!SLAVE_MODE && matchNow && !pMatch && newL && newR) |-> (busyNL && !busyNR));

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (enL && !wrSelL && oeL) |=> rvalidL);

  assert_hold_left_R9: assert property (@(posedge clk) disable iff (rst)
    (!busyNL && enL && !wrSelL && pEnL && addrL == pAddrL && !pWrL) |=> $stable(rdataL));

  assert_hold_right_R9: assert property (@(posedge clk) disable iff (rst)
    (!busyNR && enR && !wrSelR && pEnR && addrR == pAddrR && !pWrR) |=> $stable(rdataR));

  assert_slave_mirror_R10: assert property (@(posedge clk) disable iff (rst)
    SLAVE_MODE |-> (busyNL == busyInNL));

endmodule

bind twin_port_ram twin_port_ram_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLAVE_MODE(SLAVE_MODE)
) chk (
  .clk(clk), .rst(rst), .enL(enL), .wrSelL(wrSelL), .oeL(oeL), .addrL(addrL),
  .busyInNL(busyInNL), .rdataL(rdataL), .rvalidL(rvalidL), .busyNL(busyNL),
  .enR(enR), .wrSelR(wrSelR), .addrR(addrR), .rdataR(rdataR), .busyNR(busyNR)
);

// File: tb/twin_port_ram_test.sv
`timescale 1ns/1ps
module twin_port_ram_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        enL = 0, wrL = 0, oeL = 0, enR = 0, wrR = 0, oeR = 0;
  logic [10:0] aL = '0, aR = '0;
  logic [7:0]  dL = '0, dR = '0;
  logic [7:0]  rdL, rdR, sRdL, sRdR;
  logic        rvL, rvR, sRvL, sRvR, bL, bR, sBL, sBR;

  twin_port_ram uut (
    .clk(clk), .rst(rst),
    .enL(enL), .wrSelL(wrL), .oeL(oeL), .addrL(aL), .wdataL(dL), .busyInNL(1'b1),
    .rdataL(rdL), .rvalidL(rvL), .busyNL(bL),
    .enR(enR), .wrSelR(wrR), .oeR(oeR), .addrR(aR), .wdataR(dR), .busyInNR(1'b1),
    .rdataR(rdR), .rvalidR(rvR), .busyNR(bR)
  );

  twin_port_ram #(.SLAVE_MODE(1'b1)) uutSlave (
    .clk(clk), .rst(rst),
    .enL(enL), .wrSelL(wrL), .oeL(oeL), .addrL(aL), .wdataL(dL), .busyInNL(bL),
    .rdataL(sRdL), .rvalidL(sRvL), .busyNL(sBL),
    .enR(enR), .wrSelR(wrR), .oeR(oeR), .addrR(aR), .wdataR(dR), .busyInNR(bR),
    .rdataR(sRdR), .rvalidR(sRvR), .busyNR(sBR)
  );

  int nRun = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  logic [7:0]  refMem [2048];
  int          mOwner = 0;
  logic        mPEnL = 0, mPEnR = 0, mPWrL = 0, mPWrR = 0;
  logic [10:0] mPAL = '0, mPAR = '0;
  logic [7:0]  expRdL = '0, expRdR = '0;
  logic        expRvL = 0, expRvR = 0;

  function automatic logic [7:0] patt(input int i);
    return 8'((i * 29 + 7) ^ (i >> 4));
  endfunction

  // inputs already driven; checks busy before the edge, outputs after it
  task automatic step(input string tB, input string tD);
    logic match, stL, stR, eBL, eBR;
    int own;
    #1;
    match = enL && enR && (aL == aR);
    stL = enL && mPEnL && (aL == mPAL);
    stR = enR && mPEnR && (aR == mPAR);
    if (!match) own = 0;
    else if (mOwner != 0) own = mOwner;
    else if (stR && !stL) own = 2;
    else own = 1;
    eBL = !(match && own == 2);
    eBR = !(match && own == 1);
    chk(tB, "busyL", 32'(bL), 32'(eBL));
    chk(tB, "busyR", 32'(bR), 32'(eBR));
    chk("R10", "slave busyL mirror", 32'(sBL), 32'(bL));
    chk("R10", "slave busyR mirror", 32'(sBR), 32'(bR));
    if (enL && !wrL && !(!eBL && mPEnL && aL == mPAL && !mPWrL)) expRdL = refMem[aL];
    if (enR && !wrR && !(!eBR && mPEnR && aR == mPAR && !mPWrR)) expRdR = refMem[aR];
    if (enR && wrR && eBR) refMem[aR] = dR;
    if (enL && wrL && eBL) refMem[aL] = dL;
    expRvL = enL && !wrL && oeL;
    expRvR = enR && !wrR && oeR;
    mOwner = own;
    mPEnL = enL; mPEnR = enR; mPWrL = wrL; mPWrR = wrR; mPAL = aL; mPAR = aR;
    @(posedge clk);
    #1;
    chk(tD, "rdataL", 32'(rdL), 32'(expRdL));
    chk(tD, "rdataR", 32'(rdR), 32'(expRdR));
    chk(tD, "rvalidL", 32'(rvL), 32'(expRvL));
    chk(tD, "rvalidR", 32'(rvR), 32'(expRvR));
    chk("R10", "slave rdataL", 32'(sRdL), 32'(expRdL));
    chk("R10", "slave rdataR", 32'(sRdR), 32'(expRdR));
    chk("R10", "slave rvalidL", 32'(sRvL), 32'(expRvL));
  endtask

  task automatic cyc(input logic eL, input logic wl, input logic ol, input int al, input logic [7:0] dl,
                     input logic eR, input logic wr, input logic orr, input int ar, input logic [7:0] dr,
                     input string tB, input string tD);
    enL = eL; wrL = wl; oeL = ol; aL = al[10:0]; dL = dl;
    enR = eR; wrR = wr; oeR = orr; aR = ar[10:0]; dR = dr;
    step(tB, tD);
  endtask

  task automatic idle();
    cyc(0,0,0,0,0, 0,0,0,0,0, "R7", "R2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "busyL in reset", 32'(bL), 1);
    chk("R1", "busyR in reset", 32'(bR), 1);
    chk("R1", "rdataL in reset", 32'(rdL), 0);
    chk("R1", "rvalidR in reset", 32'(rvR), 0);
    rst = 1'b0;
    cyc(0,0,0,0,0, 0,0,0,0,0, "R1", "R1");
    chk("R1", "rdataR after reset", 32'(rdR), 0);

    // R3 fill through the left port
    for (int i = 0; i < 2048; i++) cyc(1,1,0,i,patt(i), 0,0,0,0,0, "R3", "R3");

    // R2 plain reads on both ports
    cyc(1,0,1,5,0, 1,0,1,100,0, "R7", "R2");
    chk("R2", "read left 5", 32'(rdL), 32'(patt(5)));
    chk("R2", "read right 100", 32'(rdR), 32'(patt(100)));
    chk("R2", "valid with oe", 32'(rvL), 1);
    cyc(1,0,0,6,0, 0,0,0,0,0, "R7", "R2");
    chk("R2", "valid gated by oe", 32'(rvL), 0);
    chk("R2", "data without oe", 32'(rdL), 32'(patt(6)));

    // R3 no write with enable low or write select low
    cyc(0,1,0,7,8'hAA, 1,0,0,9,8'h55, "R7", "R3");
    cyc(1,0,1,7,0, 1,0,1,9,0, "R7", "R3");
    chk("R3", "disabled write ignored", 32'(rdL), 32'(patt(7)));
    chk("R3", "read-select write ignored", 32'(rdR), 32'(patt(9)));

    // R6 and R4 simultaneous start, same address
    idle();
    cyc(1,0,1,200,0, 1,0,1,200,0, "R6", "R4");
    chk("R6", "tie left not busy", 32'(bL), 1);
    chk("R6", "tie right busy", 32'(bR), 0);
    chk("R4", "shared read left", 32'(rdL), 32'(patt(200)));
    chk("R4", "shared read right", 32'(rdR), 32'(patt(200)));

    // R5 earlier port wins
    idle();
    cyc(1,0,1,300,0, 0,0,0,0,0, "R5", "R2");
    cyc(1,0,1,300,0, 1,0,1,300,0, "R5", "R2");
    chk("R5", "left first: right busy", 32'(bR), 0);
    chk("R5", "left first: left free", 32'(bL), 1);
    idle();
    cyc(0,0,0,0,0, 1,0,1,400,0, "R5", "R2");
    cyc(1,0,1,400,0, 1,0,1,400,0, "R5", "R2");
    chk("R5", "right first: left busy", 32'(bL), 0);
    chk("R5", "right first: right free", 32'(bR), 1);
    chk("R10", "slave left busy copy", 32'(sBL), 0);

    // R7 release on mismatch and on enable low
    cyc(1,0,1,401,0, 1,0,1,400,0, "R7", "R2");
    chk("R7", "mismatch releases left", 32'(bL), 1);
    cyc(1,0,1,401,0, 1,0,1,401,0, "R5", "R2");
    chk("R5", "stable left wins", 32'(bR), 0);
    cyc(1,0,1,401,0, 0,0,1,401,0, "R7", "R2");
    chk("R7", "enable low releases right", 32'(bR), 1);

    // R8 write from busy port suppressed
    idle();
    cyc(0,0,0,0,0, 1,0,1,500,0, "R5", "R2");
    cyc(1,1,0,500,8'h5A, 1,0,1,500,0, "R8", "R8");
    chk("R8", "writer is busy", 32'(bL), 0);
    idle();
    cyc(1,0,1,500,0, 0,0,0,0,0, "R7", "R8");
    chk("R8", "blocked write left memory", 32'(rdL), 32'(patt(500)));

    // R9 held read while the winner writes
    idle();
    cyc(1,0,1,600,0, 0,0,0,0,0, "R7", "R2");
    cyc(1,0,1,600,0, 1,0,1,600,0, "R5", "R9");
    chk("R9", "loser loads old word", 32'(rdR), 32'(patt(600)));
    cyc(1,1,0,600,8'hC3, 1,0,1,600,0, "R5", "R9");
    chk("R9", "held during write", 32'(rdR), 32'(patt(600)));
    cyc(1,1,0,600,8'hC3, 1,0,1,600,0, "R5", "R9");
    chk("R9", "still held", 32'(rdR), 32'(patt(600)));
    cyc(0,0,0,0,0, 1,0,1,600,0, "R7", "R9");
    chk("R9", "updated after release", 32'(rdR), 32'h0C3);

    // R11 two writes in one cycle
    cyc(1,1,0,700,8'h11, 1,1,0,701,8'h22, "R7", "R11");
    cyc(1,0,1,700,0, 1,0,1,701,0, "R7", "R11");
    chk("R11", "left write kept", 32'(rdL), 32'h11);
    chk("R11", "right write kept", 32'(rdR), 32'h22);

    // random two-port traffic on a narrow window
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 2, 800 + ($urandom % 4), 8'($urandom),
          ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 2, 800 + ($urandom % 4), 8'($urandom),
          "R5", "R9");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule